// File: doc/BRIEF.md
# Thermal Sensor Scan Supervisor

This block polls a small set of temperature sensor channels on a timer. It reads them through a request/acknowledge handshake to a shared converter. Each 12-bit result is stored per channel and compared against two per-channel limits.

- A lower limit raises an interrupt.
- A second limit triggers a thermal shutdown.

The converter code falls as the die heats, so a channel counts as over a limit when its code is strictly below that limit. A limit of zero therefore never trips. An event fires only after a programmable number of consecutive over-limit samples.

Interrupt events set sticky pending bits, which drive a level interrupt through per-channel enables. Shutdown events are steered per channel to a pin aimed at the reset controller, to a pin aimed at an external power-management device, or to both. The selected pin latches until reset, with a selectable active level. While any enabled channel is part-way through its debounce, the poll timer uses a shorter reload value. A simple write-strobe bus with combinational read data configures the block and reads it back. The timer unit is `TICK_DIV` clock cycles.

Top module: `thermal_scan_ctrl`

## Requirements
- R1: After reset the block is in its idle state:
  - control (0x04), interrupt enable (0x08), pending (0x0C) and every channel data register read 0.
  - The normal period (0x68) reads 250, the hot period (0x6C) reads 50, and both debounce counts (0x60 interrupt, 0x64 shutdown) read 4.
  - `irq` and `adc_req` are low, and both shutdown pins are high (inactive, active-low default).
- R2: No converter request is made while control bit 0 is clear. While it is set, each poll requests, in ascending channel order, only the channels whose control bit 4+ch is set.
- R3: At most one request is outstanding. `adc_req` and `adc_ch` stay unchanged until `adc_ack` is seen.
- R4: The data register at 0x20+4*ch holds the last code taken for channel ch. It reads 0 until a conversion of that channel has completed.
- R5: Interrupt pending bit ch (0x0C bit ch) is set when the code of channel ch is below its interrupt limit (0x30+4*ch) on N consecutive samples, where N is the interrupt debounce count. A sample at or above the limit restarts the count.
- R6: Writing 0x0C clears each pending bit written as 0 and keeps each bit written as 1. Bit 8 of 0x0C flags that a shutdown event occurred, and any write to 0x0C clears it.
- R7: `irq` is high exactly when some pending bit ch is set together with interrupt-enable bit ch (0x08 bit ch).
- R8: After N consecutive samples of channel ch below its shutdown limit (0x40+4*ch), where N is the shutdown debounce count:
  - `shut_gpio` asserts if 0x08 bit 4+ch is set.
  - `shut_rst` asserts if 0x08 bit 8+ch is set.
  - Both stay asserted until reset, even when control bit 0 is cleared.
- R9: Control bit 8 selects the active level of both shutdown pins: 0 active low, 1 active high.
- R10: Polls start every normal-period units of `TICK_DIV` cycles. While any source-enabled channel has a nonzero debounce count, the hot period is used instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| adc_req | output | 1 | Conversion request |
| adc_ch | output | 2 | Channel of the request |
| adc_ack | input | 1 | Conversion done, code valid this cycle |
| adc_code | input | 12 | Conversion result |
| irq | output | 1 | Level interrupt |
| shut_gpio | output | 1 | Shutdown pin toward power management |
| shut_rst | output | 1 | Shutdown pin toward reset controller |

## Verification
Data, pending and shutdown state all change at the clock edge that samples `adc_ack` with `adc_req` high. That edge affects:
- the data registers,
- the pending bits and the shutdown flag,
- the shutdown latches, with `irq` and the pins following combinationally.

The bench's converter model counts completed samples per channel. Checks wait on those counts and sample on the following falling edge, so they never race an update. A new request appears one cycle after a poll starts. The poll period is checked as a window of request spacing spanning one timer unit, because the prescaler runs freely. Request order is checked by a queue of expected channels, which the converter model pops on each request.

// File: rtl/thermal_scan_pkg.sv
package thermal_scan_pkg;
   localparam logic [7:0] A_CTRL  = 8'h04;
   localparam logic [7:0] A_IEN   = 8'h08;
   localparam logic [7:0] A_PEND  = 8'h0C;
   localparam logic [7:0] A_DATA  = 8'h20;
   localparam logic [7:0] A_ITHR  = 8'h30;
   localparam logic [7:0] A_STHR  = 8'h40;
   localparam logic [7:0] A_IDBC  = 8'h60;
   localparam logic [7:0] A_SDBC  = 8'h64;
   localparam logic [7:0] A_PNORM = 8'h68;
   localparam logic [7:0] A_PHOT  = 8'h6C;
   localparam int B_SRC    = 4;
   localparam int B_POL    = 8;
   localparam int B_GPIO   = 4;
   localparam int B_RST    = 8;
   localparam int B_SHFLAG = 8;
   typedef enum logic {SEQ_IDLE, SEQ_SCAN} seq_state_e;
endpackage

// File: rtl/ts_tick_timer.sv
module ts_tick_timer #(
   parameter int TICK_DIV = 4,
   parameter int PER_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             hot,
   input  logic [PER_W-1:0] norm_per,
   input  logic [PER_W-1:0] hot_per,
   output logic             start
);
   logic             unit_tick;
   logic [PER_W-1:0] per_q;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end else if (TICK_DIV == 1) begin : g_nodiv
         assign unit_tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(TICK_DIV);
         logic [PW-1:0] pres_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pres_q <= '0;
            else if (!en)                        pres_q <= '0;
            else if (pres_q == PW'(TICK_DIV-1))  pres_q <= '0;
            else                                 pres_q <= pres_q + 1'b1;
         end
         assign unit_tick = (pres_q == PW'(TICK_DIV-1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           per_q <= '0;
      else if (!en)         per_q <= '0;
      else if (per_q == '0) per_q <= hot ? hot_per : norm_per;
      else if (unit_tick)   per_q <= per_q - 1'b1;
   end

   assign start = en && (per_q == '0);

   // the count only rises by a reload taken at zero
   assert_per_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q > $past(per_q)) |-> ($past(per_q) == '0));
endmodule

// File: rtl/ts_scan_seq.sv
module ts_scan_seq
   import thermal_scan_pkg::*;
#(
   parameter int NUM_CH = 3,
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start,
   input  logic [NUM_CH-1:0] src_en,
   input  logic              adc_ack,
   output logic              adc_req,
   output logic [CH_W-1:0]   adc_ch,
   output logic              res_vld,
   output logic [CH_W-1:0]   res_ch
);
   seq_state_e        state_q;
   logic [NUM_CH-1:0] todo_q, avail;
   logic [CH_W-1:0]   pick;

   assign avail = todo_q & src_en;

   always_comb begin
      pick = '0;
      for (int i = NUM_CH-1; i >= 0; i--)
         if (avail[i]) pick = CH_W'(i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         todo_q  <= '0;
         adc_req <= 1'b0;
         adc_ch  <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: if (start && en) begin
               todo_q  <= src_en;
               state_q <= SEQ_SCAN;
            end
            default: begin
               if (adc_req) begin
                  if (adc_ack) begin
                     adc_req        <= 1'b0;
                     todo_q[adc_ch] <= 1'b0;
                  end
               end else if (!en || avail == '0) begin
                  todo_q  <= '0;
                  state_q <= SEQ_IDLE;
               end else begin
                  adc_req <= 1'b1;
                  adc_ch  <= pick;
               end
            end
         endcase
      end
   end

   assign res_vld = adc_req && adc_ack;
   assign res_ch  = adc_ch;

   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_req && !adc_ack) |=> (adc_req && $stable(adc_ch)));
endmodule

// File: rtl/ts_chan_mon.sv
module ts_chan_mon #(
   parameter int CODE_W = 12,
   parameter int DBC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] int_thr,
   input  logic [CODE_W-1:0] shut_thr,
   input  logic [DBC_W-1:0]  int_dbc,
   input  logic [DBC_W-1:0]  shut_dbc,
   output logic              int_fire,
   output logic              shut_fire,
   output logic              busy,
   output logic [CODE_W-1:0] data
);
   logic [DBC_W-1:0] icnt_q, scnt_q, ieff, seff;
   logic             ihot, shot;

   // a zero count behaves as one sample
   assign ieff = (int_dbc  == '0) ? DBC_W'(1) : int_dbc;
   assign seff = (shut_dbc == '0) ? DBC_W'(1) : shut_dbc;
   assign ihot = code < int_thr;
   assign shot = code < shut_thr;

   assign int_fire  = vld && ihot && (DBC_W'(icnt_q + 1'b1) == ieff);
   assign shut_fire = vld && shot && (DBC_W'(scnt_q + 1'b1) == seff);
   assign busy      = (icnt_q != '0) || (scnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         icnt_q <= '0;
         scnt_q <= '0;
         data   <= '0;
      end else if (vld) begin
         data   <= code;
         icnt_q <= !ihot ? '0 : ((icnt_q < ieff) ? icnt_q + 1'b1 : icnt_q);
         scnt_q <= !shot ? '0 : ((scnt_q < seff) ? scnt_q + 1'b1 : scnt_q);
      end
   end

   assert_data_upd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data) |-> $past(vld));
   assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (icnt_q > $past(icnt_q)) |-> $past(vld && ihot));
endmodule

// File: rtl/thermal_scan_ctrl.sv
module thermal_scan_ctrl
   import thermal_scan_pkg::*;
#(
   parameter int NUM_CH   = 3,
   parameter int CODE_W   = 12,
   parameter int PER_W    = 16,
   parameter int DBC_W    = 8,
   parameter int TICK_DIV = 4,
   parameter int DEF_NORM = 250,
   parameter int DEF_HOT  = 50,
   parameter int DEF_DBC  = 4,
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              adc_req,
   output logic [CH_W-1:0]   adc_ch,
   input  logic              adc_ack,
   input  logic [CODE_W-1:0] adc_code,
   output logic              irq,
   output logic              shut_gpio,
   output logic              shut_rst
);
   generate
      if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
         $error("NUM_CH must lie in 1..4");
      end
      if (CODE_W > 16 || PER_W > 16 || DBC_W > 16) begin : g_bad_w
         $error("CODE_W, PER_W and DBC_W must not exceed 16");
      end
   endgenerate

   logic              glb_en_q, pol_q, shflag_q, lat_gpio_q, lat_rst_q;
   logic [NUM_CH-1:0] src_en_q, ien_q, route_gpio_q, route_rst_q, pend_q;
   logic [CODE_W-1:0] ithr_q [NUM_CH];
   logic [CODE_W-1:0] sthr_q [NUM_CH];
   logic [CODE_W-1:0] data_w [NUM_CH];
   logic [DBC_W-1:0]  idbc_q, sdbc_q;
   logic [PER_W-1:0]  pnorm_q, phot_q;
   logic [NUM_CH-1:0] int_fire, shut_fire, mon_busy;
   logic              start, res_vld, wr_pend, hot;
   logic [CH_W-1:0]   res_ch;
   logic              unused_bus;

   assign unused_bus = ^bus_wdata;
   assign wr_pend    = bus_wr && (bus_addr == A_PEND);
   assign hot        = |(src_en_q & mon_busy);

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_en_q     <= 1'b0;
         pol_q        <= 1'b0;
         src_en_q     <= '0;
         ien_q        <= '0;
         route_gpio_q <= '0;
         route_rst_q  <= '0;
         idbc_q       <= DBC_W'(DEF_DBC);
         sdbc_q       <= DBC_W'(DEF_DBC);
         pnorm_q      <= PER_W'(DEF_NORM);
         phot_q       <= PER_W'(DEF_HOT);
         for (int i = 0; i < NUM_CH; i++) begin
            ithr_q[i] <= '0;
            sthr_q[i] <= '0;
         end
      end else if (bus_wr) begin
         if (bus_addr == A_CTRL) begin
            glb_en_q <= bus_wdata[0];
            src_en_q <= bus_wdata[B_SRC +: NUM_CH];
            pol_q    <= bus_wdata[B_POL];
         end
         if (bus_addr == A_IEN) begin
            ien_q        <= bus_wdata[0 +: NUM_CH];
            route_gpio_q <= bus_wdata[B_GPIO +: NUM_CH];
            route_rst_q  <= bus_wdata[B_RST +: NUM_CH];
         end
         if (bus_addr == A_IDBC)  idbc_q  <= bus_wdata[DBC_W-1:0];
         if (bus_addr == A_SDBC)  sdbc_q  <= bus_wdata[DBC_W-1:0];
         if (bus_addr == A_PNORM) pnorm_q <= bus_wdata[PER_W-1:0];
         if (bus_addr == A_PHOT)  phot_q  <= bus_wdata[PER_W-1:0];
         for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == A_ITHR + 8'(4*i)) ithr_q[i] <= bus_wdata[CODE_W-1:0];
            if (bus_addr == A_STHR + 8'(4*i)) sthr_q[i] <= bus_wdata[CODE_W-1:0];
         end
      end
   end

   // event state: pending bits, shutdown flag, shutdown latches
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= '0;
         shflag_q   <= 1'b0;
         lat_gpio_q <= 1'b0;
         lat_rst_q  <= 1'b0;
      end else begin
         pend_q     <= (wr_pend ? (pend_q & bus_wdata[NUM_CH-1:0]) : pend_q) | int_fire;
         shflag_q   <= (wr_pend ? 1'b0 : shflag_q) | (|shut_fire);
         lat_gpio_q <= lat_gpio_q | (|(shut_fire & route_gpio_q));
         lat_rst_q  <= lat_rst_q  | (|(shut_fire & route_rst_q));
      end
   end

   assign irq       = |(pend_q & ien_q);
   assign shut_gpio = pol_q ? lat_gpio_q : ~lat_gpio_q;
   assign shut_rst  = pol_q ? lat_rst_q  : ~lat_rst_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[0]               = glb_en_q;
            bus_rdata[B_SRC +: NUM_CH] = src_en_q;
            bus_rdata[B_POL]           = pol_q;
         end
         A_IEN: begin
            bus_rdata[0 +: NUM_CH]      = ien_q;
            bus_rdata[B_GPIO +: NUM_CH] = route_gpio_q;
            bus_rdata[B_RST +: NUM_CH]  = route_rst_q;
         end
         A_PEND: begin
            bus_rdata[0 +: NUM_CH] = pend_q;
            bus_rdata[B_SHFLAG]    = shflag_q;
         end
         A_IDBC:  bus_rdata[DBC_W-1:0] = idbc_q;
         A_SDBC:  bus_rdata[DBC_W-1:0] = sdbc_q;
         A_PNORM: bus_rdata[PER_W-1:0] = pnorm_q;
         A_PHOT:  bus_rdata[PER_W-1:0] = phot_q;
         default: ;
      endcase
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == A_DATA + 8'(4*i)) bus_rdata[CODE_W-1:0] = data_w[i];
         if (bus_addr == A_ITHR + 8'(4*i)) bus_rdata[CODE_W-1:0] = ithr_q[i];
         if (bus_addr == A_STHR + 8'(4*i)) bus_rdata[CODE_W-1:0] = sthr_q[i];
      end
   end

   ts_tick_timer #(.TICK_DIV(TICK_DIV), .PER_W(PER_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .en(glb_en_q), .hot(hot),
      .norm_per(pnorm_q), .hot_per(phot_q), .start(start));

   ts_scan_seq #(.NUM_CH(NUM_CH)) i_seq (
      .clk(clk), .rst_n(rst_n), .en(glb_en_q), .start(start), .src_en(src_en_q),
      .adc_ack(adc_ack), .adc_req(adc_req), .adc_ch(adc_ch),
      .res_vld(res_vld), .res_ch(res_ch));

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_mon
         ts_chan_mon #(.CODE_W(CODE_W), .DBC_W(DBC_W)) i_mon (
            .clk(clk), .rst_n(rst_n),
            .vld(res_vld && (res_ch == CH_W'(g))), .code(adc_code),
            .int_thr(ithr_q[g]), .shut_thr(sthr_q[g]),
            .int_dbc(idbc_q), .shut_dbc(sdbc_q),
            .int_fire(int_fire[g]), .shut_fire(shut_fire[g]),
            .busy(mon_busy[g]), .data(data_w[g]));
      end
   endgenerate

   assert_shut_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(lat_gpio_q) && !$fell(lat_rst_q));
   assert_pend_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_q & ~$past(pend_q))) |-> $past(res_vld));
endmodule

// File: tb/test_thermal_scan_ctrl.sv
module test_thermal_scan_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        adc_req;
   logic [1:0]  adc_ch;
   logic        adc_ack = 1'b0;
   logic [11:0] adc_code = '0;
   logic        irq, shut_gpio, shut_rst;

   int checks = 0, fails = 0, cyc = 0, req_count = 0;
   int t1_prev = 0, t1_last = 0;
   int nsamp [3] = '{0, 0, 0};
   logic [11:0] codes [3] = '{12'd3700, 12'd3700, 12'd3690};
   int exp_q [$];
   logic [31:0] rv;

   thermal_scan_ctrl i_thermal_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_req(adc_req),
      .adc_ch(adc_ch), .adc_ack(adc_ack), .adc_code(adc_code),
      .irq(irq), .shut_gpio(shut_gpio), .shut_rst(shut_rst));

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_samp(input int ch, input int n);
      int target;
      target = nsamp[ch] + n;
      while (nsamp[ch] < target) @(negedge clk);
      @(negedge clk);
   endtask

   // converter model and scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && adc_req) begin
            automatic int ch = int'(adc_ch);
            req_count++;
            if (ch == 1) begin t1_prev = t1_last; t1_last = cyc; end
            if (exp_q.size() > 0) check("R2 scan order", 32'(ch), 32'(exp_q.pop_front()));
            repeat (2) @(negedge clk);
            check("R3 request held", {adc_req, 30'd0, 1'b0} | 32'(adc_ch), {1'b1, 30'd0, 1'b0} | 32'(ch));
            adc_code = codes[ch];
            adc_ack = 1'b1;
            @(negedge clk);
            adc_ack = 1'b0;
            nsamp[ch]++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int rc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 reset state
      rd(8'h04, rv); check("R1 ctrl", rv, 0);
      rd(8'h68, rv); check("R1 normal period", rv, 250);
      rd(8'h6C, rv); check("R1 hot period", rv, 50);
      rd(8'h60, rv); check("R1 int debounce", rv, 4);
      rd(8'h64, rv); check("R1 shut debounce", rv, 4);
      rd(8'h0C, rv); check("R1 pending", rv, 0);
      rd(8'h24, rv); check("R1/R4 data ch1 empty", rv, 0);
      check("R1 pins", {29'd0, irq, shut_gpio, shut_rst}, 32'b011);

      wr(8'h68, 10); wr(8'h6C, 4); wr(8'h60, 2); wr(8'h64, 3);
      wr(8'h34, 3600); wr(8'h44, 3500); wr(8'h38, 3600);
      wr(8'h04, 32'h60);             // sources on, global off
      repeat (100) @(negedge clk);
      check("R2 no request while disabled", req_count, 0);

      for (int k = 0; k < 3; k++) begin exp_q.push_back(1); exp_q.push_back(2); end
      wr(8'h04, 32'h61);
      wait_samp(1, 3);
      check_rng("R10 normal period", t1_last - t1_prev, 36, 41);
      rd(8'h24, rv); check("R4 data ch1", rv, 3700);
      rd(8'h28, rv); check("R4 data ch2", rv, 3690);
      rd(8'h20, rv); check("R4 disabled ch0 empty", rv, 0);
      check("R2 queue drained", exp_q.size(), 0);

      // R5 interrupt debounce on ch1
      wr(8'h08, 32'h2);
      codes[1] = 3550;
      wait_samp(1, 1);
      rd(8'h0C, rv); check("R5 one sample not enough", rv, 0);
      wait_samp(1, 1);
      rd(8'h0C, rv); check("R5 pending after two", rv, 32'h2);
      check("R7 irq high", irq, 1);
      wait_samp(1, 2);
      check_rng("R10 hot period", t1_last - t1_prev, 12, 17);

      // R6 write-zero-to-clear
      wr(8'h0C, 32'h2);
      rd(8'h0C, rv); check("R6 written one keeps", rv, 32'h2);
      wr(8'h0C, 32'h0);
      rd(8'h0C, rv); check("R6 written zero clears", rv, 0);
      check("R7 irq low", irq, 0);

      // R5 restart on ch2: hot, cool, hot
      codes[2] = 3550; wait_samp(2, 1);
      codes[2] = 3700; wait_samp(2, 1);
      codes[2] = 3550; wait_samp(2, 1);
      rd(8'h0C, rv); check("R5 broken run no pending", rv, 0);
      wait_samp(2, 1);
      rd(8'h0C, rv); check("R5 ch2 pending", rv, 32'h4);
      check("R7 irq masked", irq, 0);
      wr(8'h0C, 32'h0);
      codes[2] = 3700;

      // R8 shutdown of ch1 routed to gpio pin
      wr(8'h08, 32'h22);
      codes[1] = 3400;
      wait_samp(1, 2);
      check("R8 not yet", {shut_gpio, shut_rst}, 2'b11);
      wait_samp(1, 1);
      check("R8 gpio asserted", {shut_gpio, shut_rst}, 2'b01);
      rd(8'h0C, rv); check("R6 shutdown flag", rv[8], 1);
      wr(8'h0C, 32'h1FF);
      rd(8'h0C, rv); check("R6 flag cleared", rv[8], 0);

      wr(8'h04, 32'h60);
      codes[1] = 3700;
      repeat (30) @(negedge clk);
      rc = req_count;
      repeat (200) @(negedge clk);
      check("R2 stopped", req_count, rc);
      check("R8 latched after disable", shut_gpio, 0);
      wr(8'h04, 32'h160);
      check("R9 active high", {shut_gpio, shut_rst}, 2'b10);

      // second run after reset: reset-controller route
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      check("R1 pins after reset", {shut_gpio, shut_rst}, 2'b11);
      rd(8'h24, rv); check("R4 empty after reset", rv, 0);
      wr(8'h68, 10); wr(8'h6C, 4); wr(8'h48, 3500); wr(8'h08, 32'h400);
      wr(8'h04, 32'h150);
      check("R9 idle high-pol", {shut_gpio, shut_rst}, 2'b00);
      codes[0] = 3720; codes[2] = 3400;
      for (int k = 0; k < 2; k++) begin exp_q.push_back(0); exp_q.push_back(2); end
      wr(8'h04, 32'h151);
      wait_samp(2, 3);
      check("R8 rst not yet", shut_rst, 0);
      wait_samp(2, 1);
      check("R8 rst asserted", {shut_gpio, shut_rst}, 2'b01);
      check("R2 queue drained", exp_q.size(), 0);
      rd(8'h20, rv); check("R4 data ch0", rv, 3720);
      rd(8'h24, rv); check("R4 ch1 skipped", rv, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule